// File: doc/BRIEF.md
# Calendar and Time-of-Day Counter with Alarm

This block holds the current time and date as seven byte-wide fields (seconds, minutes, hours, day of week, date, month, year). It steps forward by one second on each cycle in which the one-hertz tick enable is high. The seconds carry into minutes, then hours, then the day fields, then month and year. February is 29 days long in leap years. A mode register selects one of two byte encodings, plain binary or packed BCD, and one of two hour formats, 24-hour or 12-hour with a PM flag in bit 7 of the hours byte. The same register holds a hold bit that freezes counting while a host reloads the fields.

After every advance the new time is compared with three alarm bytes for seconds, minutes and hours. An alarm byte whose two top bits are both 1 matches any value. The block raises a one-cycle update-done pulse for every advance it makes, and a one-cycle alarm pulse in the same cycle when the new time matches.

A host loads fields, alarm bytes and the mode register through a single-cycle write port. A write that arrives in the same cycle as a tick wins, and that tick is dropped.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the outputs read seconds 00, minutes 00, hours 00, day of week 01, date 01, month 01 and year 00, with both pulses low. The mode is 24-hour BCD with counting enabled.
- R2: In 24-hour mode each accepted tick adds one second. Seconds wrap from 59 to 0, minutes wrap from 59 to 0, hours wrap from 23 to 0, and each wrap carries into the next field. With no tick and no write, all outputs hold.
- R3: The date wraps to 1 after the last day of the month. April, June, September and November have 30 days. February has 29 days when the year is divisible by 4 and 28 otherwise. All other months have 31 days. The month wraps from 12 to 1 and the year wraps from 99 to 00.
- R4: The day of week advances on every day change and wraps from 7 back to 1.
- R5: Bit 1 of the mode register selects the encoding of every time and alarm byte: 1 means binary and 0 means packed BCD, with tens in bits 7:4.
- R6: Bit 2 of the mode register selects the hour format: 1 means 24-hour and 0 means 12-hour. In 12-hour mode the hours run 12, 1, ..., 11, and bit 7 of the hours byte is PM. PM toggles on the step from 11 to 12, and the day advances on the step from 11 PM to 12 AM.
- R7: While bit 0 of the mode register (hold) is 1, ticks are ignored. The fields keep their values and no update-done pulse appears.
- R8: Each accepted tick produces exactly one update-done pulse, high for one cycle in the cycle after the tick, together with the new field values.
- R9: In the same cycle as the update-done pulse, the alarm pulse is high exactly when the new seconds, minutes and hours bytes each match their alarm byte. The hours comparison includes the PM bit.
- R10: An alarm byte with bits 7:6 equal to 11 matches any value of its field.
- R11: A write to the register map takes effect in the next cycle. The map is: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 8 seconds alarm, 9 minutes alarm, 10 hours alarm, 15 mode. A write in the same cycle as a tick takes precedence, and that tick produces no advance and no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-second advance enable, one cycle wide |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | ADDR_W | Host write register address |
| wr_data_i | input | 8 | Host write data |
| sec_o | output | 8 | Seconds byte |
| min_o | output | 8 | Minutes byte |
| hour_o | output | 8 | Hours byte (bit 7 is PM in 12-hour mode) |
| dow_o | output | 8 | Day-of-week byte |
| date_o | output | 8 | Day-of-month byte |
| mon_o | output | 8 | Month byte |
| year_o | output | 8 | Year byte |
| alarm_o | output | 1 | Alarm match pulse |
| update_done_o | output | 1 | Advance-completed pulse |

## Verification
A tick sampled at a rising edge produces its new field values, its update-done pulse and its alarm pulse all after that same edge. A write likewise appears on the outputs one edge after it is presented. The driver changes inputs on falling edges and pushes the expected state for each tick into a queue. The monitor compares every field and the alarm flag on the falling edge where update-done is high, which is half a cycle after the updating edge. Held and overridden ticks are checked on that same falling edge for the absence of the pulse and for unchanged or written values.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int A_SEC   = 0;
    localparam int A_MIN   = 1;
    localparam int A_HOUR  = 2;
    localparam int A_DOW   = 3;
    localparam int A_DATE  = 4;
    localparam int A_MON   = 5;
    localparam int A_YEAR  = 6;
    localparam int A_ASEC  = 8;
    localparam int A_AMIN  = 9;
    localparam int A_AHOUR = 10;
    localparam int A_MODE  = 15;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] dow;
        logic [7:0] date;
        logic [7:0] mon;
        logic [7:0] year;
    } cal_t;

    typedef struct packed {
        logic h24;
        logic bin;
        logic hold;
    } mode_t;

    // decode a stored byte into a plain number
    function automatic logic [7:0] to_num(input logic [7:0] v, input logic bin);
        logic [7:0] tens;
        logic [7:0] ones;
        tens = 8'(v[7:4]);
        ones = 8'(v[3:0]);
        return bin ? v : (tens * 8'd10 + ones);
    endfunction

    // encode a plain number (0..127) into the selected byte format
    function automatic logic [7:0] from_num(input logic [6:0] n, input logic bin);
        logic [6:0] t;
        logic [6:0] u;
        t = n / 7'd10;
        u = n % 7'd10;
        return bin ? {1'b0, n} : {t[3:0], u[3:0]};
    endfunction

endpackage

// File: rtl/rtc_field_step.sv
module rtc_field_step
    import rtc_cal_pkg::*;
(
    input  logic [7:0] val_i,
    input  logic       bin_i,
    input  logic [6:0] lo_i,
    input  logic [6:0] hi_i,
    input  logic       carry_i,
    output logic [7:0] val_o,
    output logic       carry_o
);
    logic [7:0] cur;

    always_comb begin
        cur     = to_num(val_i, bin_i);
        val_o   = val_i;
        carry_o = 1'b0;
        if (carry_i) begin
            if (cur >= {1'b0, hi_i}) begin
                val_o   = from_num(lo_i, bin_i);
                carry_o = 1'b1;
            end else begin
                val_o   = from_num(cur[6:0] + 7'd1, bin_i);
            end
        end
    end
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step
    import rtc_cal_pkg::*;
(
    input  logic [7:0] val_i,
    input  logic       bin_i,
    input  logic       h24_i,
    input  logic       carry_i,
    output logic [7:0] val_o,
    output logic       carry_o
);
    logic [7:0] cur;
    logic [6:0] nxt;
    logic [7:0] enc;
    logic       pm_n;

    always_comb begin
        val_o   = val_i;
        carry_o = 1'b0;
        pm_n    = val_i[7];
        nxt     = '0;
        enc     = '0;
        if (h24_i) begin
            cur = to_num(val_i, bin_i);
            if (carry_i) begin
                if (cur >= 8'd23) begin
                    val_o   = from_num(7'd0, bin_i);
                    carry_o = 1'b1;
                end else begin
                    val_o   = from_num(cur[6:0] + 7'd1, bin_i);
                end
            end
        end else begin
            cur = to_num({1'b0, val_i[6:0]}, bin_i);
            if (carry_i) begin
                if (cur == 8'd11) begin
                    nxt     = 7'd12;
                    pm_n    = ~val_i[7];
                    carry_o = val_i[7];
                end else if (cur >= 8'd12) begin
                    nxt = 7'd1;
                end else begin
                    nxt = cur[6:0] + 7'd1;
                end
                enc   = from_num(nxt, bin_i);
                val_o = {pm_n, enc[6:0]};
            end
        end
    end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
    parameter int N = 3
) (
    input  logic [N-1:0][7:0] cur_i,
    input  logic [N-1:0][7:0] alm_i,
    output logic              match_o
);
    logic [N-1:0] hit;

    for (genvar i = 0; i < N; i++) begin : g_byte
        assign hit[i] = (alm_i[i][7:6] == 2'b11) || (alm_i[i] == cur_i[i]);
    end

    assign match_o = &hit;
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int WEEK_DAYS = 7,
    parameter int YEAR_SPAN = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    output logic [7:0]        sec_o,
    output logic [7:0]        min_o,
    output logic [7:0]        hour_o,
    output logic [7:0]        dow_o,
    output logic [7:0]        date_o,
    output logic [7:0]        mon_o,
    output logic [7:0]        year_o,
    output logic              alarm_o,
    output logic              update_done_o
);
    localparam int N_ALM = 3;
    localparam logic [6:0] YEAR_TOP = 7'(YEAR_SPAN - 1);
    localparam logic [6:0] DOW_TOP  = 7'(WEEK_DAYS);

    typedef struct packed {
        cal_t                  cal;
        logic [N_ALM-1:0][7:0] alm;
        mode_t                 mode;
        logic                  alarm;
        logic                  done;
    } state_t;

    state_t state_d, state_q;

    logic       advance;
    logic [7:0] mon_n, yr_n;
    logic [6:0] month_days;
    logic       leap;
    cal_t       nxt;
    logic       c_sec, c_min, c_hour, c_dow, c_date, c_mon, c_year;
    logic       alm_hit;

    assign advance = tick_i && !wr_en_i && !state_q.mode.hold;

    // length of the current month
    always_comb begin
        mon_n = to_num(state_q.cal.mon, state_q.mode.bin);
        yr_n  = to_num(state_q.cal.year, state_q.mode.bin);
        leap  = (yr_n[1:0] == 2'b00);
        case (mon_n)
            8'd2:                      month_days = leap ? 7'd29 : 7'd28;
            8'd4, 8'd6, 8'd9, 8'd11:   month_days = 7'd30;
            default:                   month_days = 7'd31;
        endcase
    end

    rtc_field_step u_sec (
        .val_i(state_q.cal.sec), .bin_i(state_q.mode.bin), .lo_i(7'd0), .hi_i(7'd59),
        .carry_i(advance), .val_o(nxt.sec), .carry_o(c_sec));

    rtc_field_step u_min (
        .val_i(state_q.cal.min), .bin_i(state_q.mode.bin), .lo_i(7'd0), .hi_i(7'd59),
        .carry_i(c_sec), .val_o(nxt.min), .carry_o(c_min));

    rtc_hour_step u_hour (
        .val_i(state_q.cal.hour), .bin_i(state_q.mode.bin), .h24_i(state_q.mode.h24),
        .carry_i(c_min), .val_o(nxt.hour), .carry_o(c_hour));

    rtc_field_step u_dow (
        .val_i(state_q.cal.dow), .bin_i(state_q.mode.bin), .lo_i(7'd1), .hi_i(DOW_TOP),
        .carry_i(c_hour), .val_o(nxt.dow), .carry_o(c_dow));

    rtc_field_step u_date (
        .val_i(state_q.cal.date), .bin_i(state_q.mode.bin), .lo_i(7'd1), .hi_i(month_days),
        .carry_i(c_hour), .val_o(nxt.date), .carry_o(c_date));

    rtc_field_step u_mon (
        .val_i(state_q.cal.mon), .bin_i(state_q.mode.bin), .lo_i(7'd1), .hi_i(7'd12),
        .carry_i(c_date), .val_o(nxt.mon), .carry_o(c_mon));

    rtc_field_step u_year (
        .val_i(state_q.cal.year), .bin_i(state_q.mode.bin), .lo_i(7'd0), .hi_i(YEAR_TOP),
        .carry_i(c_mon), .val_o(nxt.year), .carry_o(c_year));

    rtc_alarm_cmp #(.N(N_ALM)) u_alarm (
        .cur_i({nxt.hour, nxt.min, nxt.sec}),
        .alm_i(state_q.alm),
        .match_o(alm_hit));

    always_comb begin
        state_d       = state_q;
        state_d.alarm = 1'b0;
        state_d.done  = 1'b0;
        if (advance) begin
            state_d.cal   = nxt;
            state_d.done  = 1'b1;
            state_d.alarm = alm_hit;
        end
        if (wr_en_i) begin
            case (wr_addr_i)
                ADDR_W'(A_SEC):   state_d.cal.sec  = wr_data_i;
                ADDR_W'(A_MIN):   state_d.cal.min  = wr_data_i;
                ADDR_W'(A_HOUR):  state_d.cal.hour = wr_data_i;
                ADDR_W'(A_DOW):   state_d.cal.dow  = wr_data_i;
                ADDR_W'(A_DATE):  state_d.cal.date = wr_data_i;
                ADDR_W'(A_MON):   state_d.cal.mon  = wr_data_i;
                ADDR_W'(A_YEAR):  state_d.cal.year = wr_data_i;
                ADDR_W'(A_ASEC):  state_d.alm[0]   = wr_data_i;
                ADDR_W'(A_AMIN):  state_d.alm[1]   = wr_data_i;
                ADDR_W'(A_AHOUR): state_d.alm[2]   = wr_data_i;
                ADDR_W'(A_MODE):  state_d.mode     = wr_data_i[2:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q          <= '0;
            state_q.cal.dow  <= 8'h01;
            state_q.cal.date <= 8'h01;
            state_q.cal.mon  <= 8'h01;
            state_q.mode.h24 <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign sec_o         = state_q.cal.sec;
    assign min_o         = state_q.cal.min;
    assign hour_o        = state_q.cal.hour;
    assign dow_o         = state_q.cal.dow;
    assign date_o        = state_q.cal.date;
    assign mon_o         = state_q.cal.mon;
    assign year_o        = state_q.cal.year;
    assign alarm_o       = state_q.alarm;
    assign update_done_o = state_q.done;

    // R8
    done_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        update_done_o |-> $past(tick_i));

    // R7
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.mode.hold && !wr_en_i) |=> ($stable(sec_o) && !update_done_o));

    // R9
    alarm_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_o |-> update_done_o);

    // R11
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && tick_i) |=> !update_done_o);

    // R2
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !wr_en_i) |=> $stable({sec_o, min_o, hour_o, dow_o, date_o, mon_o, year_o}));

endmodule

// File: tb/rtc_calendar_core_tb_top.sv
`timescale 1ns/1ps
module rtc_calendar_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [3:0] wr_addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, mon_o, year_o;
    logic       alarm_o, update_done_o;

    always #2.5 clk = ~clk;

    rtc_calendar_core dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
        .date_o(date_o), .mon_o(mon_o), .year_o(year_o),
        .alarm_o(alarm_o), .update_done_o(update_done_o));

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    // reference model, plain numbers
    int ms, mm, mh, mdw, md, mmo, my;
    bit mpm, mbin, mh24, mhold;
    logic [7:0] a_s, a_m, a_h;

    typedef struct {
        logic [7:0] f[7];
        bit         alarm;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    function automatic logic [7:0] enc(int v);
        return mbin ? 8'(v) : 8'(((v / 10) << 4) + (v % 10));
    endfunction

    function automatic logic [7:0] hour_byte();
        logic [7:0] e;
        e = enc(mh);
        return mh24 ? e : {mpm, e[6:0]};
    endfunction

    function automatic int dim(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic bit alm_ok(logic [7:0] a, logic [7:0] v);
        return (a[7:6] == 2'b11) || (a == v);
    endfunction

    task automatic check8(string req, string what, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic next_day();
        mdw = (mdw == 7) ? 1 : mdw + 1;
        md++;
        if (md > dim(mmo, my)) begin
            md = 1;
            mmo++;
            if (mmo > 12) begin
                mmo = 1;
                my = (my + 1) % 100;
            end
        end
    endtask

    task automatic model_step();
        ms++;
        if (ms == 60) begin
            ms = 0;
            mm++;
            if (mm == 60) begin
                mm = 0;
                if (mh24) begin
                    mh++;
                    if (mh == 24) begin mh = 0; next_day(); end
                end else if (mh == 11) begin
                    mh = 12;
                    if (mpm) begin mpm = 0; next_day(); end
                    else mpm = 1;
                end else if (mh == 12) mh = 1;
                else mh++;
            end
        end
    endtask

    function automatic exp_t snapshot(string tag);
        exp_t e;
        e.f[0] = enc(ms);  e.f[1] = enc(mm);  e.f[2] = hour_byte();
        e.f[3] = enc(mdw); e.f[4] = enc(md);  e.f[5] = enc(mmo); e.f[6] = enc(my);
        e.alarm = alm_ok(a_s, e.f[0]) && alm_ok(a_m, e.f[1]) && alm_ok(a_h, e.f[2]);
        e.tag = tag;
        return e;
    endfunction

    task automatic compare_now(exp_t e);
        check8(e.tag, "sec",   sec_o,  e.f[0]);
        check8(e.tag, "min",   min_o,  e.f[1]);
        check8(e.tag, "hour",  hour_o, e.f[2]);
        check8(e.tag, "dow",   dow_o,  e.f[3]);
        check8(e.tag, "date",  date_o, e.f[4]);
        check8(e.tag, "month", mon_o,  e.f[5]);
        check8(e.tag, "year",  year_o, e.f[6]);
    endtask

    // monitor: pops one expected item per update-done pulse
    always @(negedge clk) begin
        if (rst_n && update_done_o) begin
            if (sb_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R8 unexpected update-done actual=1 expected=0");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                compare_now(e);
                check8({e.tag, " R9"}, "alarm", {7'd0, alarm_o}, {7'd0, e.alarm});
            end
        end
    end

    task automatic wr(int addr, logic [7:0] data);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = 4'(addr); wr_data_i = data;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic set_mode(bit hold, bit bin, bit h24);
        mhold = hold; mbin = bin; mh24 = h24;
        wr(15, {5'd0, h24, bin, hold});
    endtask

    task automatic set_alarm(logic [7:0] s, logic [7:0] m, logic [7:0] h);
        a_s = s; a_m = m; a_h = h;
        wr(8, s); wr(9, m); wr(10, h);
    endtask

    // R11: load all fields then read them back at the ports
    task automatic load(int s, int m, int h, bit pm, int dw, int d, int mo, int y);
        ms = s; mm = m; mh = h; mpm = pm; mdw = dw; md = d; mmo = mo; my = y;
        wr(0, enc(s)); wr(1, enc(m)); wr(2, hour_byte()); wr(3, enc(dw));
        wr(4, enc(d)); wr(5, enc(mo)); wr(6, enc(y));
        compare_now(snapshot("R11 load"));
    endtask

    // driver: pushes the expected state, then pulses the tick
    task automatic tick(string tag);
        logic [7:0] s_before;
        s_before = sec_o;
        if (!mhold) begin
            model_step();
            sb_q.push_back(snapshot(tag));
        end
        @(negedge clk); tick_i = 1'b1;
        @(negedge clk); tick_i = 1'b0;
        if (mhold) begin
            check8("R7 hold", "done", {7'd0, update_done_o}, 8'd0);
            check8("R7 hold", "sec", sec_o, s_before);
        end
        @(negedge clk);
        check8({tag, " R8"}, "pending", 8'(sb_q.size()), 8'd0);
        check8({tag, " R8"}, "done width", {7'd0, update_done_o}, 8'd0);
    endtask

    task automatic finish_run();
        ended = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            total++; bad++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        mbin = 0; mh24 = 1; mhold = 0; mpm = 0;
        a_s = 0; a_m = 0; a_h = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        ms = 0; mm = 0; mh = 0; mdw = 1; md = 1; mmo = 1; my = 0;
        compare_now(snapshot("R1 reset"));
        check8("R1 reset", "alarm", {7'd0, alarm_o}, 8'd0);
        check8("R1 reset", "done", {7'd0, update_done_o}, 8'd0);
        set_alarm(8'h3F, 8'h3F, 8'h3F);  // unreachable in BCD

        // R2 / R3 / R4 in BCD 24-hour
        load(58, 59, 23, 0, 7, 28, 2, 24);
        tick("R2 second step");
        tick("R3 R4 leap feb 28 to 29, dow 7 to 1");
        load(59, 59, 23, 0, 3, 29, 2, 24);
        tick("R3 leap feb 29 to mar 1");
        load(59, 59, 23, 0, 3, 28, 2, 23);
        tick("R3 common feb to mar 1");
        load(59, 59, 23, 0, 5, 31, 12, 99);
        tick("R3 year 99 wraps to 00");
        load(59, 59, 23, 0, 2, 30, 4, 10);
        tick("R3 30-day month wrap");
        load(59, 59, 9, 0, 2, 30, 5, 10);
        tick("R2 hour carry 09 to 10 bcd");

        // R5 binary encoding
        set_mode(0, 1, 1);
        load(59, 59, 23, 0, 6, 31, 1, 5);
        tick("R5 binary day rollover");
        tick("R5 binary second step");
        load(59, 39, 15, 0, 1, 10, 7, 40);
        tick("R5 binary minute carry");

        // R6 12-hour, BCD
        set_mode(0, 0, 0);
        load(59, 59, 11, 0, 2, 14, 6, 30);
        tick("R6 11am to 12pm");
        load(59, 59, 11, 1, 2, 15, 6, 30);
        tick("R6 11pm to 12am next day");
        load(59, 59, 12, 0, 2, 16, 6, 30);
        tick("R6 12 to 1");
        set_mode(0, 1, 0);
        load(59, 59, 11, 1, 7, 31, 12, 99);
        tick("R6 R5 binary 12-hour year end");

        // R7 hold
        set_mode(1, 0, 1);
        load(10, 0, 5, 0, 1, 1, 1, 1);
        tick("R7 held 1");
        tick("R7 held 2");
        compare_now(snapshot("R7 held fields"));
        set_mode(0, 0, 1);
        tick("R7 resumed");

        // R9 exact alarm
        set_alarm(8'h30, 8'h20, 8'h10);
        load(28, 20, 10, 0, 1, 1, 1, 1);
        tick("R9 no match yet");
        tick("R9 exact match");
        tick("R9 past match");

        // R10 wildcards
        set_alarm(8'hC0, 8'h21, 8'h10);
        load(57, 20, 10, 0, 1, 1, 1, 1);
        tick("R10 seconds wildcard before minute");
        tick("R10 seconds wildcard in minute");
        tick("R10 seconds wildcard next second");
        set_alarm(8'h05, 8'hFF, 8'hE3);
        load(3, 44, 7, 0, 1, 1, 1, 1);
        tick("R10 hour minute wildcard miss");
        tick("R10 hour minute wildcard hit");
        set_alarm(8'hC1, 8'hD2, 8'hFF);
        tick("R10 all wildcard");
        tick("R10 all wildcard again");

        // R11 write beats a same-cycle tick
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = 4'd0; wr_data_i = 8'h42; tick_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; tick_i = 1'b0;
        check8("R11 write wins", "sec", sec_o, 8'h42);
        check8("R11 write wins", "done", {7'd0, update_done_o}, 8'd0);
        ms = 42;
        @(negedge clk);
        compare_now(snapshot("R11 other fields kept"));

        repeat (3) @(negedge clk);
        check8("R8 final", "queue", 8'(sb_q.size()), 8'd0);
        finish_run();
    end

endmodule